// File: doc/BRIEF.md
# Data EEPROM Refresh Sequencer

This block rewrites every location of a byte-addressable data EEPROM array with its own contents. That renews the charge in cells holding values that change rarely. A single start pulse launches a run. The sequencer clears its address counter to zero and raises write-enable toward the memory's write controller. It asks the interrupt controller to mask interrupts, and then works through the array one location at a time.

For each location, the sequencer reads the current byte and presents the two-byte unlock key. It then strobes a write of the same byte back to the same address and waits for the memory to drop its busy flag. The run ends when the address counter wraps past its top value. At that point write-enable and the interrupt mask are released together, and a one-cycle done pulse is given.

An abort input ends a run early: the location in progress is still completed before the release. The memory behind the port is outside the block. In the bench it is a register file with a programmable write latency.

The controller has ten states:
- IDLE waits for start.
- ARM clears the address and raises mask and write-enable.
- READ issues the read strobe.
- CAPTURE latches the returned byte.
- KEY1 presents 55h.
- KEY2 presents AAh.
- STROBE issues the write strobe.
- WAIT holds while memory is busy.
- NEXT steps the address.
- FINISH releases mask and write-enable and pulses done.

The transitions are:
- IDLE→ARM on start.
- ARM→READ.
- READ→CAPTURE→KEY1→KEY2→STROBE→WAIT.
- WAIT→NEXT once busy is low.
- NEXT→FINISH at the last address or after an abort, otherwise NEXT→READ.
- FINISH→IDLE.

Top module: `eer_refresh_seq`

## Requirements
- R1: A run accepted from idle clears the address counter, so the first read and the first write of every run use address 0, whatever address a previous run stopped at.
- R2: `mem_sel_data_o` is 1 (data EEPROM region selected) in every cycle where `mem_rd_o` or `mem_wr_o` is 1.
- R3: `irq_mask_o` is 1 from the cycle after start is accepted up to the last write of the run. It is 0 in the done cycle and while idle.
- R4: `mem_wren_o` is 1 from the cycle after start is accepted up to the last write of the run. It is 0 in the done cycle and while idle.
- R5: For every address, a read strobe precedes the write strobe. The byte written equals the byte the memory returned in the cycle after that read strobe.
- R6: After each write strobe, no further read or write strobe is issued while `mem_busy_i` is 1. The memory raises busy in the cycle after an accepted strobe.
- R7: Write addresses step by one, starting at 0. The run ends after the write to address 2^ADDR_W-1 (255 by default), giving exactly 256 writes.
- R8: Each write strobe follows immediately after two key cycles with `mem_key_vld_o`=1: key 8'h55 two cycles before the strobe, then key 8'hAA one cycle before it.
- R9: `done_o` is a single-cycle pulse at the end of a run. `busy_o` is 1 from the cycle after start is accepted through the done cycle, and 0 afterwards.
- R10: A start pulse while `busy_o` is 1 is ignored: the run is not restarted and still ends with one done pulse after 256 writes.
- R11: An abort during a run lets the location in progress finish its write. The run then ends with the done pulse, with write-enable and mask released and no further writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| abort_i | input | 1 | Stop request, honoured at the end of the current location |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| irq_mask_o | output | 1 | Request to mask interrupts |
| mem_sel_data_o | output | 1 | Data EEPROM region select |
| mem_addr_o | output | ADDR_W | Location address |
| mem_rd_o | output | 1 | Read strobe |
| mem_rdata_i | input | DATA_W | Read data, valid in the cycle after the read strobe |
| mem_key_vld_o | output | 1 | Unlock key byte valid |
| mem_key_o | output | 8 | Unlock key byte |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | DATA_W | Write data |
| mem_wren_o | output | 1 | Write enable level |
| mem_busy_i | input | 1 | Write in progress in memory |

## Verification
Two end conditions can coincide at the same location: the address reaching its top value and an abort request. The bench provokes this by pulsing abort in the cycle of the strobe to address 255, so the abort is taken while the final location is waiting on busy. The result passes only if the run shows exactly 256 writes, a single done pulse, and write-enable and mask low in the done cycle. A second pairing is also covered: a restart request arriving mid-run, which must be ignored and leave one done pulse.

// File: rtl/eer_pkg.sv
package eer_pkg;
    localparam int          KEY_W      = 8;
    localparam logic [7:0]  KEY_FIRST  = 8'h55;
    localparam logic [7:0]  KEY_SECOND = 8'hAA;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARM,
        ST_READ,
        ST_CAPTURE,
        ST_KEY1,
        ST_KEY2,
        ST_STROBE,
        ST_WAIT,
        ST_NEXT,
        ST_FINISH
    } state_t;
endpackage

// File: rtl/eer_addr_ctr.sv
module eer_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   addr <= '0;
        else if (clr) addr <= '0;
        else if (inc) addr <= addr + 1'b1;
    end

    assign at_last = (addr == TOP);

    // R7: one step per increment, wrapping modulo the address width
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (addr == $past(addr) + 1'b1));
    // R1: a clear brings the counter back to zero
    assert_addr_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr == '0));
endmodule

// File: rtl/eer_byte_hold.sv
module eer_byte_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    // R5: the held byte is exactly what was returned at capture
    assert_hold_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dout == $past(din)));
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
endmodule

// File: rtl/eer_ctrl_fsm.sv
module eer_ctrl_fsm
    import eer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             mem_busy,
    input  logic             at_last,
    output logic             ctr_clr,
    output logic             ctr_inc,
    output logic             hold_load,
    output logic             rd,
    output logic             wr,
    output logic             key_vld,
    output logic [KEY_W-1:0] key,
    output logic             wren,
    output logic             mask,
    output logic             sel,
    output logic             busy,
    output logic             done
);
    state_t state, state_nx;
    logic   abort_pend;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // abort request held until the run closes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  abort_pend <= 1'b0;
        else if (state == ST_IDLE)   abort_pend <= 1'b0;
        else if (abort)              abort_pend <= 1'b1;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_ARM;
            ST_ARM:     state_nx = ST_READ;
            ST_READ:    state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = ST_KEY1;
            ST_KEY1:    state_nx = ST_KEY2;
            ST_KEY2:    state_nx = ST_STROBE;
            ST_STROBE:  state_nx = ST_WAIT;
            ST_WAIT:    if (!mem_busy) state_nx = ST_NEXT;
            ST_NEXT:    state_nx = (at_last || abort_pend) ? ST_FINISH : ST_READ;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        ctr_clr   = 1'b0;
        ctr_inc   = 1'b0;
        hold_load = 1'b0;
        rd        = 1'b0;
        wr        = 1'b0;
        key_vld   = 1'b0;
        key       = '0;
        wren      = 1'b0;
        mask      = 1'b0;
        sel       = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ARM: begin
                ctr_clr = 1'b1;
                wren = 1'b1; mask = 1'b1; sel = 1'b1; busy = 1'b1;
            end
            ST_READ: begin
                rd = 1'b1;
                wren = 1'b1; mask = 1'b1; sel = 1'b1; busy = 1'b1;
            end
            ST_CAPTURE: begin
                hold_load = 1'b1;
                wren = 1'b1; mask = 1'b1; sel = 1'b1; busy = 1'b1;
            end
            ST_KEY1: begin
                key_vld = 1'b1; key = KEY_FIRST;
                wren = 1'b1; mask = 1'b1; sel = 1'b1; busy = 1'b1;
            end
            ST_KEY2: begin
                key_vld = 1'b1; key = KEY_SECOND;
                wren = 1'b1; mask = 1'b1; sel = 1'b1; busy = 1'b1;
            end
            ST_STROBE: begin
                wr = 1'b1;
                wren = 1'b1; mask = 1'b1; sel = 1'b1; busy = 1'b1;
            end
            ST_WAIT: begin
                wren = 1'b1; mask = 1'b1; sel = 1'b1; busy = 1'b1;
            end
            ST_NEXT: begin
                ctr_inc = 1'b1;
                wren = 1'b1; mask = 1'b1; sel = 1'b1; busy = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1; busy = 1'b1;
            end
            default: ;
        endcase
    end

    // R8: the second key byte immediately precedes every strobe
    assert_key_before_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> ($past(key_vld) && $past(key) == KEY_SECOND));
    // R6: the address only advances once memory reported not busy
    assert_wait_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NEXT) |-> !$past(mem_busy));
    // R9: done lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11: a pending abort closes the run at the end of the location
    assert_abort_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NEXT && abort_pend) |=> (state == ST_FINISH));
    // R10: start outside idle never re-arms
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state != ST_ARM));
endmodule

// File: rtl/eer_refresh_seq.sv
module eer_refresh_seq
    import eer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              irq_mask_o,
    output logic              mem_sel_data_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_key_vld_o,
    output logic [7:0]        mem_key_o,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_wren_o,
    input  logic              mem_busy_i
);
    logic ctr_clr, ctr_inc, hold_load, at_last;

    eer_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctr_clr),
        .inc     (ctr_inc),
        .addr    (mem_addr_o),
        .at_last (at_last)
    );

    eer_byte_hold #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hold_load),
        .din   (mem_rdata_i),
        .dout  (mem_wdata_o)
    );

    eer_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .abort     (abort_i),
        .mem_busy  (mem_busy_i),
        .at_last   (at_last),
        .ctr_clr   (ctr_clr),
        .ctr_inc   (ctr_inc),
        .hold_load (hold_load),
        .rd        (mem_rd_o),
        .wr        (mem_wr_o),
        .key_vld   (mem_key_vld_o),
        .key       (mem_key_o),
        .wren      (mem_wren_o),
        .mask      (irq_mask_o),
        .sel       (mem_sel_data_o),
        .busy      (busy_o),
        .done      (done_o)
    );

    // R2: region select accompanies every access
    assert_sel_on_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> mem_sel_data_o);
    // R4: write-enable is up for every strobe and down at completion
    assert_wren_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> mem_wren_o);
    assert_wren_off_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_wren_o);
    // R3: interrupts are masked for every strobe and released at completion
    assert_mask_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> irq_mask_o);
    assert_mask_off_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !irq_mask_o);
endmodule

// File: tb/eer_refresh_seq_tb.sv
module eer_refresh_seq_tb;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NLOC = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic abort = 1'b0;
    logic busy, done, mask, sel, rd, kvld, wr, wren;
    logic [AW-1:0] addr;
    logic [7:0] key;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata = '0;
    logic mbusy = 1'b0;

    always #5 clk = ~clk;

    eer_refresh_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .busy_o(busy), .done_o(done), .irq_mask_o(mask),
        .mem_sel_data_o(sel), .mem_addr_o(addr), .mem_rd_o(rd),
        .mem_rdata_i(rdata), .mem_key_vld_o(kvld), .mem_key_o(key),
        .mem_wr_o(wr), .mem_wdata_o(wdata), .mem_wren_o(wren),
        .mem_busy_i(mbusy)
    );

    // memory model: register file with programmable write latency
    logic [DW-1:0] mem [NLOC];
    logic [DW-1:0] expm [NLOC];
    int lat = 3;
    int kst = 0;
    int bcnt = 0;
    int rejects = 0;

    always @(posedge clk) begin
        if (rd) rdata <= mem[addr];
        if (wr) begin
            if (kst == 2 && wren && sel) begin
                mem[addr] <= wdata;
                mbusy <= 1'b1;
                bcnt <= lat;
            end else begin
                rejects <= rejects + 1;
            end
        end else if (mbusy) begin
            if (bcnt <= 1) mbusy <= 1'b0;
            else bcnt <= bcnt - 1;
        end
        if (kvld && key == 8'h55) kst <= 1;
        else if (kvld && key == 8'hAA && kst == 1) kst <= 2;
        else kst <= 0;
    end

    // observation of every access, away from the active edge
    int n_wr = 0, n_done = 0, first_addr = -1;
    int e_sel = 0, e_wren = 0, e_mask = 0, e_key = 0, e_addr = 0, e_data = 0, e_wait = 0, e_order = 0;
    int exp_addr = 0, last_rd = -1;
    logic [DW-1:0] last_rdata = '0;
    logic rd_d = 1'b0;
    logic kv1 = 1'b0, kv2 = 1'b0;
    logic [7:0] k1 = '0, k2 = '0;

    always @(negedge clk) begin
        if (rd_d) last_rdata = rdata;
        if (rd) begin
            if (!sel) e_sel++;
            if (mbusy) e_wait++;
            last_rd = int'(addr);
        end
        if (wr) begin
            if (!sel) e_sel++;
            if (!wren) e_wren++;
            if (!mask) e_mask++;
            if (!(kv1 && k1 == 8'hAA && kv2 && k2 == 8'h55)) e_key++;
            if (mbusy) e_wait++;
            if (int'(addr) != exp_addr) e_addr++;
            if (last_rd != int'(addr) || wdata != last_rdata || wdata != expm[addr]) e_data++;
            if (last_rd != int'(addr)) e_order++;
            if (n_wr == 0) first_addr = int'(addr);
            exp_addr = (exp_addr + 1) % NLOC;
            n_wr++;
        end
        if (done) n_done++;
        rd_d = rd;
        kv2 = kv1; k2 = k1;
        kv1 = kvld; k1 = key;
    end

    int n_checks = 0, n_err = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < NLOC; i++) begin
            mem[i] = DW'(i * seed + 5);
            expm[i] = mem[i];
        end
    endtask

    task automatic clear_mon();
        n_wr = 0; n_done = 0; first_addr = -1; exp_addr = 0; last_rd = -1;
        e_sel = 0; e_wren = 0; e_mask = 0; e_key = 0; e_addr = 0; e_data = 0; e_wait = 0; e_order = 0;
        rejects = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); #1;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk); #1;
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    task automatic check_clean(input string tag);
        check(e_sel == 0, {tag, " R2 select"}, e_sel, 0);
        check(e_data == 0 && e_order == 0, {tag, " R5 read-then-write"}, e_data, 0);
        check(e_wait == 0, {tag, " R6 busy wait"}, e_wait, 0);
        check(e_key == 0 && rejects == 0, {tag, " R8 key"}, e_key + rejects, 0);
        check(e_addr == 0, {tag, " R7 order"}, e_addr, 0);
        check(e_wren == 0, {tag, " R4 wren on strobe"}, e_wren, 0);
        check(e_mask == 0, {tag, " R3 mask on strobe"}, e_mask, 0);
    endtask

    task automatic check_close(input string tag);
        check(!mask, {tag, " R3 mask released at done"}, int'(mask), 0);
        check(!wren, {tag, " R4 wren released at done"}, int'(wren), 0);
        @(negedge clk); #1;
        check(!done, {tag, " R9 done one cycle"}, int'(done), 0);
        check(!busy, {tag, " R9 busy low after done"}, int'(busy), 0);
    endtask

    task automatic t_reset();
        check(!busy && !done, "R9 reset status", int'(busy) + int'(done), 0);
        check(!mask && !wren, "R3 R4 reset mask/wren", int'(mask) + int'(wren), 0);
        check(!rd && !wr, "R2 reset no strobe", int'(rd) + int'(wr), 0);
    endtask

    task automatic t_abort_mid();
        bit seen;
        fill(37); clear_mon(); lat = 3;
        pulse_start();
        check(busy && mask && wren, "R9 R3 R4 raised after start", int'(busy & mask & wren), 1);
        while (n_wr < 10) begin @(negedge clk); #1; end
        abort = 1'b1;
        @(negedge clk); #1;
        abort = 1'b0;
        wait_done(seen);
        check(seen, "R11 abort completes", int'(seen), 1);
        check(n_wr == 10, "R11 writes after abort", n_wr, 10);
        check_clean("abort");
        check_close("R11");
        repeat (20) @(negedge clk);
        #1 check(n_wr == 10, "R11 no writes after end", n_wr, 10);
    endtask

    task automatic t_full(input int seed, input int l);
        bit seen;
        fill(seed); clear_mon(); lat = l;
        pulse_start();
        wait_done(seen);
        check(seen, "R7 run completes", int'(seen), 1);
        check(first_addr == 0, "R1 first address", first_addr, 0);
        check(n_wr == NLOC, "R7 write count", n_wr, NLOC);
        check_clean("full");
        check_close("full");
        begin
            int bad = 0;
            for (int i = 0; i < NLOC; i++) if (mem[i] != expm[i]) bad++;
            check(bad == 0, "R5 contents preserved", bad, 0);
        end
    endtask

    task automatic t_start_ignored();
        bit seen;
        fill(11); clear_mon(); lat = 1;
        pulse_start();
        while (n_wr < 50) begin @(negedge clk); #1; end
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        wait_done(seen);
        check(n_wr == NLOC, "R10 writes with restart attempt", n_wr, NLOC);
        check(e_addr == 0, "R10 order unbroken", e_addr, 0);
        repeat (30) @(negedge clk);
        #1 check(n_done == 1, "R10 single done", n_done, 1);
    endtask

    task automatic t_abort_last();
        bit seen;
        fill(73); clear_mon(); lat = 2;
        pulse_start();
        while (n_wr < NLOC) begin @(negedge clk); #1; end
        abort = 1'b1;
        @(negedge clk); #1;
        abort = 1'b0;
        wait_done(seen);
        check(n_wr == NLOC, "R11 R7 abort at last location", n_wr, NLOC);
        check_close("R11 last");
        repeat (30) @(negedge clk);
        #1 check(n_done == 1, "R11 one done at coincidence", n_done, 1);
    endtask

    initial begin
        fill(1);
        repeat (3) @(negedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_abort_mid();
        t_full(37, 3);
        t_start_ignored();
        t_abort_last();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule